// File: doc/BRIEF.md
# Page-Mapped Logical-to-Physical Sector Translator

This block keeps the page-level address map for a small NAND array made of erase blocks, each holding a fixed number of program pages, with one logical sector (512 data bytes) filling one page. A host write for a logical sector is never done in place. The translator hands out the next unwritten page of the block that is open for writing, points the sector's map entry at that page, and drops the page the sector used before from the live count of its block. A host read returns the physical block and page of a sector, or a miss.

An outside agent reclaims space. It reads the per-block live-page counts and the free-block count and picks blocks to empty. When a block holds no live pages, it tells the translator through the same request port that the block has been erased. Each response also carries the plane of the physical address: odd blocks sit on plane 0 and even blocks on plane 1. This lets the flash sequencer pair operations across planes.

Top module: `l2p_xlate`

## Requirements
- R1: After reset, `req_ready` and `wr_avail` are 1, `rsp_valid` is 0, `free_blocks` equals NUM_BLK-1 (block 0 starts open), and every live-page count is 0.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both high) makes `req_ready` low for the next cycle. `rsp_valid` is then high for exactly the cycle after the following edge.
- R3: A read (`req_op`=0) of a sector that has never been written responds with `rsp_hit`=0, `rsp_err`=0, and block, page and plane all 0.
- R4: Writes (`req_op`=1) take pages of the open block in strictly ascending order from page 0. No page is handed out twice between erases. The response has `rsp_hit`=1 and the new address. After reset the first block opened is block 0.
- R5: A read of a written sector responds with `rsp_hit`=1 and the address given by its most recent accepted write.
- R6: Rewriting a sector moves it to a fresh page. The old page's block loses one live page and the new page's block gains one.
- R7: On every hit response, `rsp_plane` is 0 for an odd block number and 1 for an even one.
- R8: When a write fills the last page of the open block, the lowest-numbered free block becomes open and `free_blocks` drops by one. The next write goes to its page 0.
- R9: When the open block is full and no block is free, `wr_avail` is 0. A write then responds with `rsp_err`=1 and changes no map entry, count or free state.
- R10: An erase (`req_op`=2, block in `req_blk`) of a block with live pages responds with `rsp_err`=1 and changes nothing.
- R11: An erase of a block with no live pages responds with `rsp_err`=0 and rewinds that block to page 0. If a block is open for writing, the erased block joins the free pool and `free_blocks` rises by one. If no block is open, the erased block becomes the open block and `wr_avail` returns to 1.
- R12: `blk_vcnt` carries the live-page count of block b in bits [4b+3:4b], and no count exceeds the pages per block.
- R13: The reserved operation `req_op`=3 responds with `rsp_err`=1 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 erase notice, 3 reserved |
| req_lsn | input | 6 | Logical sector number for read and write |
| req_blk | input | 4 | Block number for erase notices |
| wr_avail | output | 1 | A page can be allocated for a write |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_hit | output | 1 | Response carries a valid physical address |
| rsp_blk | output | 4 | Physical block |
| rsp_page | output | 3 | Physical page within the block |
| rsp_plane | output | 1 | Plane of the physical block |
| free_blocks | output | 5 | Number of erased blocks in the free pool |
| blk_vcnt | output | 64 | Packed live-page counts, 4 bits per block |

## Verification
Every request takes a fixed two edges. The edge that accepts it is followed one cycle later by the edge that commits the map and count updates and registers the response. The bench drives at a falling edge and checks `req_ready` low at the next falling edge. It reads the response at the falling edge after that, where `rsp_valid` must be high. The counts and free total are sampled at that same point or later, since they change on the commit edge. Allocation order is checked through a full exhaustion of the array. The erase cases are run both with a block open and with none open.

// File: rtl/l2p_pkg.sv
package l2p_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } l2p_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } l2p_state_e;

  // Odd blocks live on plane 0, even blocks on plane 1.
  function automatic logic plane_of(input logic blk_lsb);
    return ~blk_lsb;
  endfunction

endpackage

// File: rtl/l2p_map_tbl.sv
module l2p_map_tbl #(
  parameter int NUM_LSN = 64,
  parameter int BLK_W   = 4,
  parameter int PG_W    = 3,
  localparam int LSN_W  = $clog2(NUM_LSN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LSN_W-1:0] rd_lsn,
  output logic             rd_vld,
  output logic [BLK_W-1:0] rd_blk,
  output logic [PG_W-1:0]  rd_pg,
  input  logic             we,
  input  logic [LSN_W-1:0] wr_lsn,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [PG_W-1:0]  wr_pg
);

  logic             vld_q [NUM_LSN];
  logic [BLK_W-1:0] blk_q [NUM_LSN];
  logic [PG_W-1:0]  pg_q  [NUM_LSN];

  for (genvar s = 0; s < NUM_LSN; s++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (wr_lsn == LSN_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        blk_q[s] <= '0;
        pg_q[s]  <= '0;
      end else if (ent_en) begin
        vld_q[s] <= 1'b1;
        blk_q[s] <= wr_blk;
        pg_q[s]  <= wr_pg;
      end
    end
  end

  assign rd_vld = vld_q[rd_lsn];
  assign rd_blk = blk_q[rd_lsn];
  assign rd_pg  = pg_q[rd_lsn];

endmodule

// File: rtl/l2p_lowfree.sv
module l2p_lowfree #(
  parameter int N       = 16,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic [N-1:0]     free_map,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] cnt
);

  always_comb begin
    idx = '0;
    cnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_map[i]) idx = IDX_W'(i);
      cnt = cnt + {{(CNT_W-1){1'b0}}, free_map[i]};
    end
    any = |free_map;
  end

endmodule

// File: rtl/l2p_blk_state.sv
module l2p_blk_state #(
  parameter int NUM_BLK    = 16,
  parameter int PG_PER_BLK = 8,
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int PG_W      = $clog2(PG_PER_BLK),
  localparam int WP_W      = $clog2(PG_PER_BLK + 1),
  localparam int CNT_W     = $clog2(PG_PER_BLK + 1),
  localparam int FREE_W    = $clog2(NUM_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     inv_en,
  input  logic [BLK_W-1:0]         inv_blk,
  input  logic                     er_en,
  input  logic [BLK_W-1:0]         er_blk,
  output logic                     er_allowed,
  output logic [BLK_W-1:0]         open_blk,
  output logic [PG_W-1:0]          open_pg,
  output logic                     open_ok,
  output logic [FREE_W-1:0]        free_cnt,
  output logic [NUM_BLK*CNT_W-1:0] vcnt_flat
);

  logic [CNT_W-1:0]   vcnt_q [NUM_BLK];
  logic [CNT_W-1:0]   vcnt_n [NUM_BLK];
  logic [WP_W-1:0]    wp_q   [NUM_BLK];
  logic [WP_W-1:0]    wp_n   [NUM_BLK];
  logic [NUM_BLK-1:0] free_q, free_n;
  logic [BLK_W-1:0]   open_q, open_n;
  logic               ok_q, ok_n;
  logic               upd_en;

  logic               any_free;
  logic [BLK_W-1:0]   low_idx;

  l2p_lowfree #(.N(NUM_BLK)) u_low (
    .free_map (free_q),
    .any      (any_free),
    .idx      (low_idx),
    .cnt      (free_cnt)
  );

  always_comb begin
    vcnt_n = vcnt_q;
    wp_n   = wp_q;
    free_n = free_q;
    open_n = open_q;
    ok_n   = ok_q;
    if (wr_en) begin
      vcnt_n[open_q] = vcnt_n[open_q] + CNT_W'(1);
      wp_n[open_q]   = wp_q[open_q] + WP_W'(1);
      if (wp_q[open_q] == WP_W'(PG_PER_BLK - 1)) begin
        if (any_free) begin
          open_n          = low_idx;
          free_n[low_idx] = 1'b0;
        end else begin
          ok_n = 1'b0;
        end
      end
    end
    if (inv_en) begin
      vcnt_n[inv_blk] = vcnt_n[inv_blk] - CNT_W'(1);
    end
    if (er_en) begin
      wp_n[er_blk] = '0;
      if (!ok_q) begin
        open_n = er_blk;
        ok_n   = 1'b1;
      end else if (er_blk != open_q) begin
        free_n[er_blk] = 1'b1;
      end
    end
  end

  assign upd_en = wr_en | er_en;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vcnt_q[b] <= '0;
        wp_q[b]   <= '0;
      end else if (upd_en) begin
        vcnt_q[b] <= vcnt_n[b];
        wp_q[b]   <= wp_n[b];
      end
    end
    assign vcnt_flat[b*CNT_W +: CNT_W] = vcnt_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= {{(NUM_BLK-1){1'b1}}, 1'b0};
      open_q <= '0;
      ok_q   <= 1'b1;
    end else if (upd_en) begin
      free_q <= free_n;
      open_q <= open_n;
      ok_q   <= ok_n;
    end
  end

  assign er_allowed = (vcnt_q[er_blk] == '0);
  assign open_blk   = open_q;
  assign open_pg    = wp_q[open_q][PG_W-1:0];
  assign open_ok    = ok_q;

endmodule

// File: rtl/l2p_xlate.sv
module l2p_xlate #(
  parameter int NUM_BLK    = 16,
  parameter int PG_PER_BLK = 8,
  parameter int NUM_LSN    = 64,
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int PG_W      = $clog2(PG_PER_BLK),
  localparam int LSN_W     = $clog2(NUM_LSN),
  localparam int CNT_W     = $clog2(PG_PER_BLK + 1),
  localparam int FREE_W    = $clog2(NUM_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [LSN_W-1:0]         req_lsn,
  input  logic [BLK_W-1:0]         req_blk,
  output logic                     wr_avail,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic                     rsp_hit,
  output logic [BLK_W-1:0]         rsp_blk,
  output logic [PG_W-1:0]          rsp_page,
  output logic                     rsp_plane,
  output logic [FREE_W-1:0]        free_blocks,
  output logic [NUM_BLK*CNT_W-1:0] blk_vcnt
);
  import l2p_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  l2p_state_e       state_q, state_n;
  l2p_op_e          op_q;
  logic [LSN_W-1:0] lsn_q;
  logic [BLK_W-1:0] eblk_q;
  logic             accept, exec;

  logic             ent_vld;
  logic [BLK_W-1:0] ent_blk;
  logic [PG_W-1:0]  ent_pg;

  logic             er_allowed, open_ok;
  logic [BLK_W-1:0] open_blk;
  logic [PG_W-1:0]  open_pg;

  logic             map_we, wr_en, inv_en, er_en;
  logic             nx_err, nx_hit;
  logic [BLK_W-1:0] nx_blk;
  logic [PG_W-1:0]  nx_pg;

  logic             rsp_vld_q, rsp_err_q, rsp_hit_q, rsp_plane_q;
  logic [BLK_W-1:0] rsp_blk_q;
  logic [PG_W-1:0]  rsp_pg_q;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign exec   = (state_q == ST_EXEC);

  // Next state
  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_n = ST_EXEC;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q   <= OP_READ;
      lsn_q  <= '0;
      eblk_q <= '0;
    end else if (accept) begin
      op_q   <= l2p_op_e'(req_op);
      lsn_q  <= req_lsn;
      eblk_q <= req_blk;
    end
  end

  l2p_map_tbl #(
    .NUM_LSN (NUM_LSN),
    .BLK_W   (BLK_W),
    .PG_W    (PG_W)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_lsn (lsn_q),
    .rd_vld (ent_vld),
    .rd_blk (ent_blk),
    .rd_pg  (ent_pg),
    .we     (map_we),
    .wr_lsn (lsn_q),
    .wr_blk (open_blk),
    .wr_pg  (open_pg)
  );

  l2p_blk_state #(
    .NUM_BLK    (NUM_BLK),
    .PG_PER_BLK (PG_PER_BLK)
  ) u_blk (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (wr_en),
    .inv_en     (inv_en),
    .inv_blk    (ent_blk),
    .er_en      (er_en),
    .er_blk     (eblk_q),
    .er_allowed (er_allowed),
    .open_blk   (open_blk),
    .open_pg    (open_pg),
    .open_ok    (open_ok),
    .free_cnt   (free_blocks),
    .vcnt_flat  (blk_vcnt)
  );

  // Execute-cycle decode: commit strobes and response values
  always_comb begin
    map_we = 1'b0;
    wr_en  = 1'b0;
    inv_en = 1'b0;
    er_en  = 1'b0;
    nx_err = 1'b0;
    nx_hit = 1'b0;
    nx_blk = '0;
    nx_pg  = '0;
    case (op_q)
      OP_READ: begin
        if (ent_vld) begin
          nx_hit = 1'b1;
          nx_blk = ent_blk;
          nx_pg  = ent_pg;
        end
      end
      OP_WRITE: begin
        if (open_ok) begin
          map_we = exec;
          wr_en  = exec;
          inv_en = exec && ent_vld;
          nx_hit = 1'b1;
          nx_blk = open_blk;
          nx_pg  = open_pg;
        end else begin
          nx_err = 1'b1;
        end
      end
      OP_ERASE: begin
        if (er_allowed) er_en  = exec;
        else            nx_err = 1'b1;
      end
      default: nx_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rsp_vld_q <= 1'b0;
    else          rsp_vld_q <= exec;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_err_q   <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_blk_q   <= '0;
      rsp_pg_q    <= '0;
      rsp_plane_q <= 1'b0;
    end else if (exec) begin
      rsp_err_q   <= nx_err;
      rsp_hit_q   <= nx_hit;
      rsp_blk_q   <= nx_blk;
      rsp_pg_q    <= nx_pg;
      rsp_plane_q <= nx_hit && plane_of(nx_blk[0]);
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign wr_avail  = open_ok;
  assign rsp_valid = rsp_vld_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_blk   = rsp_blk_q;
  assign rsp_page  = rsp_pg_q;
  assign rsp_plane = rsp_plane_q;

endmodule

// File: rtl/l2p_xlate_chk.sv
module l2p_xlate_chk #(
  parameter int NUM_BLK    = 16,
  parameter int PG_PER_BLK = 8,
  parameter int NUM_LSN    = 64,
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int PG_W      = $clog2(PG_PER_BLK),
  localparam int CNT_W     = $clog2(PG_PER_BLK + 1),
  localparam int FREE_W    = $clog2(NUM_BLK + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     wr_avail,
  input logic                     rsp_valid,
  input logic                     rsp_err,
  input logic                     rsp_hit,
  input logic [BLK_W-1:0]         rsp_blk,
  input logic [PG_W-1:0]          rsp_page,
  input logic                     rsp_plane,
  input logic [FREE_W-1:0]        free_blocks,
  input logic [NUM_BLK*CNT_W-1:0] blk_vcnt
);

  // R2: accepted request gives one-cycle gap, then response
  assert_accept_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid) ##1 rsp_valid);

  // R2: response lasts a single cycle
  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: a miss carries an all-zero address
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_blk == '0 && rsp_page == '0 && !rsp_plane));

  // R7: plane follows block parity on hits
  assert_plane_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_plane != rsp_blk[0]));

  // R9: write availability drops only with an empty free pool
  assert_avail_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_avail) |-> (free_blocks == '0));

  // R10: a rejected request leaves counts and pool untouched
  assert_reject_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> ($stable(free_blocks) && $stable(blk_vcnt)));

  // R12: no block reports more live pages than it holds
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_cap
    assert_vcnt_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vcnt[b*CNT_W +: CNT_W] <= CNT_W'(PG_PER_BLK));
  end

endmodule

bind l2p_xlate l2p_xlate_chk #(
  .NUM_BLK    (NUM_BLK),
  .PG_PER_BLK (PG_PER_BLK),
  .NUM_LSN    (NUM_LSN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .wr_avail    (wr_avail),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_hit     (rsp_hit),
  .rsp_blk     (rsp_blk),
  .rsp_page    (rsp_page),
  .rsp_plane   (rsp_plane),
  .free_blocks (free_blocks),
  .blk_vcnt    (blk_vcnt)
);

// File: tb/sim_l2p_xlate.sv
`timescale 1ns/1ps
module sim_l2p_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [5:0]  req_lsn;
  logic [3:0]  req_blk;
  logic        wr_avail;
  logic        rsp_valid, rsp_err, rsp_hit, rsp_plane;
  logic [3:0]  rsp_blk;
  logic [2:0]  rsp_page;
  logic [4:0]  free_blocks;
  logic [63:0] blk_vcnt;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  l2p_xlate u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_op (req_op), .req_lsn (req_lsn), .req_blk (req_blk),
    .wr_avail (wr_avail),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_hit (rsp_hit),
    .rsp_blk (rsp_blk), .rsp_page (rsp_page), .rsp_plane (rsp_plane),
    .free_blocks (free_blocks), .blk_vcnt (blk_vcnt)
  );

  // {req id, op, lsn, blk, exp err, exp hit, exp blk, exp page}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {4'd3,  2'd0, 6'd5, 4'd0, 1'b0, 1'b0, 4'd0, 3'd0},  // R3 miss
    {4'd4,  2'd1, 6'd0, 4'd0, 1'b0, 1'b1, 4'd0, 3'd0},  // R4 ascending
    {4'd4,  2'd1, 6'd1, 4'd0, 1'b0, 1'b1, 4'd0, 3'd1},
    {4'd4,  2'd1, 6'd2, 4'd0, 1'b0, 1'b1, 4'd0, 3'd2},
    {4'd4,  2'd1, 6'd3, 4'd0, 1'b0, 1'b1, 4'd0, 3'd3},
    {4'd4,  2'd1, 6'd4, 4'd0, 1'b0, 1'b1, 4'd0, 3'd4},
    {4'd4,  2'd1, 6'd5, 4'd0, 1'b0, 1'b1, 4'd0, 3'd5},
    {4'd4,  2'd1, 6'd6, 4'd0, 1'b0, 1'b1, 4'd0, 3'd6},
    {4'd4,  2'd1, 6'd7, 4'd0, 1'b0, 1'b1, 4'd0, 3'd7},
    {4'd5,  2'd0, 6'd3, 4'd0, 1'b0, 1'b1, 4'd0, 3'd3},  // R5 read back
    {4'd6,  2'd1, 6'd3, 4'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R6 R8 rewrite into block 1
    {4'd10, 2'd2, 6'd0, 4'd0, 1'b1, 1'b0, 4'd0, 3'd0},  // R10 erase refused
    {4'd5,  2'd0, 6'd3, 4'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R5 R7 odd block
    {4'd13, 2'd3, 6'd9, 4'd0, 1'b1, 1'b0, 4'd0, 3'd0}   // R13 reserved op
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vc(input int b);
    return int'(blk_vcnt[b*4 +: 4]);
  endfunction

  task automatic do_req(input logic [1:0] op, input int lsn, input int blk,
                        output logic e, output logic h, output int rb,
                        output int rp, output logic pl);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_lsn   = lsn[5:0];
    req_blk   = blk[3:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !rsp_valid, "R2 busy cycle", {req_ready, rsp_valid}, 0);
    @(negedge clk);
    chk(rsp_valid, "R2 response cycle", rsp_valid, 1);
    e  = rsp_err;
    h  = rsp_hit;
    rb = int'(rsp_blk);
    rp = int'(rsp_page);
    pl = rsp_plane;
  endtask

  task automatic expect_rsp(input string tag, input logic [1:0] op, input int lsn,
                            input int blk, input logic xe, input logic xh,
                            input int xb, input int xp);
    logic e, h, pl, xpl;
    int   rb, rp;
    do_req(op, lsn, blk, e, h, rb, rp, pl);
    xpl = xh ? ~xb[0] : 1'b0;
    chk({e, h, pl} == {xe, xh, xpl} && rb == xb && rp == xp, tag,
        {e, h, pl, 4'(rb), 3'(rp)}, {xe, xh, xpl, 4'(xb), 3'(xp)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [24:0] v;
    string       tag;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = 2'd0;
    req_lsn   = '0;
    req_blk   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready && wr_avail && !rsp_valid, "R1 handshake idle",
        {req_ready, wr_avail, rsp_valid}, 3'b110);
    chk(free_blocks == 5'd15, "R1 free count", free_blocks, 15);
    chk(blk_vcnt == '0, "R1 live counts", int'(blk_vcnt[31:0]), 0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      v   = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[24:21], i);
      expect_rsp(tag, v[20:19], int'(v[18:13]), int'(v[12:9]),
                 v[8], v[7], int'(v[6:3]), int'(v[2:0]));
    end

    // R6 R8 R12 after the table
    chk(vc(0) == 7 && vc(1) == 1, "R6 counts after rewrite", vc(0) * 16 + vc(1), 7 * 16 + 1);
    chk(free_blocks == 5'd14, "R8 free after block switch", free_blocks, 14);
    chk(vc(0) == 7, "R10 count kept after refused erase", vc(0), 7);

    // Rewrite remaining sectors of block 0 into block 1
    begin
      int lsns [7] = '{0, 1, 2, 4, 5, 6, 7};
      for (int k = 0; k < 7; k++)
        expect_rsp("R6 rewrite", 2'd1, lsns[k], 0, 1'b0, 1'b1, 1, k + 1);
    end
    chk(vc(0) == 0 && vc(1) == 8, "R12 counts field", vc(0) * 16 + vc(1), 8);
    chk(free_blocks == 5'd13, "R8 free after second switch", free_blocks, 13);

    // R11 erase with an open block returns to pool
    expect_rsp("R11 erase empty block", 2'd2, 0, 0, 1'b0, 1'b0, 0, 0);
    chk(free_blocks == 5'd14, "R11 pool grows", free_blocks, 14);

    // R8 exhaustion: block 2, then lowest free (0), then 3..15
    for (int i = 0; i < 120; i++) begin
      int bseq, xb;
      bseq = i / 8;
      xb   = (bseq == 0) ? 2 : (bseq == 1) ? 0 : bseq + 1;
      expect_rsp("R8 allocation order", 2'd1, 8 + (i % 56), 0, 1'b0, 1'b1, xb, i % 8);
    end

    // R9 no space left
    @(negedge clk);
    chk(!wr_avail && free_blocks == 5'd0, "R9 space exhausted",
        {wr_avail, free_blocks}, 0);
    expect_rsp("R9 write refused", 2'd1, 15, 0, 1'b1, 1'b0, 0, 0);
    chk(vc(15) == 8 && free_blocks == 5'd0, "R9 state unchanged", vc(15), 8);
    expect_rsp("R9 mapping unchanged", 2'd0, 15, 0, 1'b0, 1'b1, 15, 7);
    chk(vc(2) == 0 && vc(0) == 0, "R12 stale blocks empty", vc(2) + vc(0), 0);

    // R11 erase with nothing open reopens that block
    expect_rsp("R11 erase reopens", 2'd2, 0, 2, 1'b0, 1'b0, 0, 0);
    @(negedge clk);
    chk(wr_avail && free_blocks == 5'd0, "R11 write space back",
        {wr_avail, free_blocks}, 6'b100000);
    expect_rsp("R11 R7 write to reopened block", 2'd1, 40, 0, 1'b0, 1'b1, 2, 0);
    expect_rsp("R11 second erase to pool", 2'd2, 0, 0, 1'b0, 1'b0, 0, 0);
    chk(free_blocks == 5'd1, "R11 pool count", free_blocks, 1);

    // R10 erase of a live block
    expect_rsp("R10 erase refused", 2'd2, 0, 1, 1'b1, 1'b0, 0, 0);
    chk(vc(1) == 8 && free_blocks == 5'd1, "R10 nothing changed", vc(1), 8);

    // R13 reserved op leaves map intact
    expect_rsp("R13 reserved", 2'd3, 40, 0, 1'b1, 1'b0, 0, 0);
    expect_rsp("R13 map intact", 2'd0, 40, 0, 1'b0, 1'b1, 2, 0);

    // R1 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(free_blocks == 5'd15 && blk_vcnt == '0 && wr_avail, "R1 re-reset",
        free_blocks, 15);
    expect_rsp("R3 R1 map cleared", 2'd0, 40, 0, 1'b0, 1'b0, 0, 0);

    finish_run();
  end

endmodule